// File: doc/BRIEF.md
# Latched Alert Controller

This block produces the active-low alert line that a power-supply management interface uses to tell its host that something has changed. It watches a vector of condition flags: input voltage low or high, output voltage low or high, output over-current, temperature warning or fault, fan failure, bus communication error, checksum error, unsupported command and internal fault. It pulls the line low whenever that vector changes in either direction. It does not react to a flag merely being high.

Once low, the line stays low until the host acknowledges. Four sources count as an acknowledgement:
- a finished status read,
- a clear-faults command,
- the main output being turned off and back on through the enable pin,
- the main output being turned off and back on through the operation-command on/off state.

If any condition flag is still set after an acknowledgement, the line goes low again one clock later and latches again. The bus protocol engine and the analog sensing sit outside this block. Condition bit positions are not distinguished: every bit is treated the same.

Top module: `alert_latch_ctrl`

## Requirements
- R1: During and after reset, with no condition flag set and no change, `alertN` is 1.
- R2: A change of any bit of `condIn`, rising or falling, drives `alertN` to 0. Sampled away from the edge, the change shows at the second rising clock edge after it appears at the input.
- R3: Once `alertN` is 0, it stays 0 while no clear source fires, whatever the condition flags do.
- R4: A one-cycle pulse on `rdStatusDone` releases `alertN` to 1 at the edge that samples the pulse.
- R5: A one-cycle pulse on `clrFaultsCmd` releases `alertN` to 1 at the edge that samples the pulse.
- R6: Driving `enablePin` from 1 to 0 does not clear the alert. Returning it from 0 to 1 releases `alertN` at the edge that first samples the 1.
- R7: Driving `opOn` from 1 to 0 does not clear the alert. Returning it from 0 to 1 releases `alertN` at the edge that first samples the 1.
- R8: One clock after a clear, `alertN` returns to 0 if any condition flag is still set. If none is set, it stays 1.
- R9: A detected condition change in the same cycle as a clear wins: `alertN` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| condIn | input | NUM_COND (12) | Condition flags, 1 = condition present |
| rdStatusDone | input | 1 | Pulse: status read transaction finished |
| clrFaultsCmd | input | 1 | Pulse: clear-faults command received |
| enablePin | input | 1 | Main output enable pin level, 1 = on |
| opOn | input | 1 | Main output on/off state from the operation command, 1 = on |
| alertN | output | 1 | Active-low latched alert |

## Verification
A stale condition snapshot shows up at the port within two clocks. Either a missed change leaves `alertN` high after the second edge, or a phantom change pulls it low with no input activity. A stuck re-check flag shows one clock after a clear: `alertN` either fails to return low while a flag is set, or drops with every flag clear. A wrong edge register on an output-cycle path clears the alert on the falling half of the cycle, or never clears it. The bench samples `alertN` on each of those edges to catch these faults.

// File: rtl/alert_pkg.sv
package alert_pkg;
  localparam int COND_W_DEF = 12;
  localparam int CYCLE_PATHS = 2;

  typedef struct packed {
    logic changeSeen;
    logic anyActive;
    logic pinCycle;
    logic opCycle;
  } evt_t;
endpackage

// File: rtl/alert_dp.sv
module alert_dp
  import alert_pkg::*;
#(
  parameter int NUM_COND = COND_W_DEF
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_COND-1:0] condIn,
  input  logic                enablePin,
  input  logic                opOn,
  output evt_t                evt
);
  logic [NUM_COND-1:0] condReg;
  logic [NUM_COND-1:0] condPrev;
  logic [NUM_COND-1:0] diffVec;
  logic [CYCLE_PATHS-1:0] pathLvl;
  logic [CYCLE_PATHS-1:0] pathRise;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      condReg  <= '0;
      condPrev <= '0;
    end else begin
      condReg  <= condIn;
      condPrev <= condReg;
    end
  end

  assign diffVec = condReg ^ condPrev;
  assign pathLvl = {opOn, enablePin};

  // One rising-edge detector per output on/off path. The history register
  // resets to 1, so a path that starts on gives no false cycle.
  for (genvar g = 0; g < CYCLE_PATHS; g++) begin : g_cyc
    logic lvlQ;
    always_ff @(posedge clk) begin
      if (!rstN) lvlQ <= 1'b1;
      else       lvlQ <= pathLvl[g];
    end
    assign pathRise[g] = pathLvl[g] & ~lvlQ;
  end

  assign evt.changeSeen = |diffVec;
  assign evt.anyActive  = |condReg;
  assign evt.pinCycle   = pathRise[0];
  assign evt.opCycle    = pathRise[1];

  // R6: a pin cycle is only seen after the pin was low on the previous clock
  a_r6_pin_needs_low: assert property (@(posedge clk) disable iff (!rstN)
    evt.pinCycle |-> !$past(enablePin));
  // R7: same for the operation path
  a_r7_op_needs_low: assert property (@(posedge clk) disable iff (!rstN)
    evt.opCycle |-> !$past(opOn));
endmodule

// File: rtl/alert_ctrl.sv
module alert_ctrl
  import alert_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  evt_t evt,
  input  logic rdStatusDone,
  input  logic clrFaultsCmd,
  output logic alertLatched
);
  logic clrAny;
  logic recheckPend;

  assign clrAny = rdStatusDone | clrFaultsCmd | evt.pinCycle | evt.opCycle;

  // Priority, highest first: new change, re-check after a clear, then the clear.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      alertLatched <= 1'b0;
      recheckPend  <= 1'b0;
    end else begin
      recheckPend <= clrAny;
      if (evt.changeSeen)
        alertLatched <= 1'b1;
      else if (recheckPend && evt.anyActive)
        alertLatched <= 1'b1;
      else if (clrAny)
        alertLatched <= 1'b0;
    end
  end

  // R2 / R9: a change always latches, even with a clear in the same cycle
  a_r2_change_latches: assert property (@(posedge clk) disable iff (!rstN)
    evt.changeSeen |=> alertLatched);
  // R3: without a clear the latch holds
  a_r3_hold_until_clear: assert property (@(posedge clk) disable iff (!rstN)
    (alertLatched && !clrAny) |=> alertLatched);
  // R4/R5: a clear with no competing event releases the latch
  a_r4_clear_releases: assert property (@(posedge clk) disable iff (!rstN)
    (clrAny && !evt.changeSeen && !(recheckPend && evt.anyActive)) |=> !alertLatched);
  // R8: flags still set one clock after a clear re-latch the alert
  a_r8_reassert: assert property (@(posedge clk) disable iff (!rstN)
    (recheckPend && evt.anyActive) |=> alertLatched);
  // R1: with no event at all the line cannot drop
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    (!alertLatched && !evt.changeSeen && !recheckPend) |=> !alertLatched);
endmodule

// File: rtl/alert_latch_ctrl.sv
module alert_latch_ctrl
  import alert_pkg::*;
#(
  parameter int NUM_COND = COND_W_DEF
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_COND-1:0] condIn,
  input  logic                rdStatusDone,
  input  logic                clrFaultsCmd,
  input  logic                enablePin,
  input  logic                opOn,
  output logic                alertN
);
  evt_t evt;
  logic alertLatched;

  alert_dp #(.NUM_COND(NUM_COND)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .condIn    (condIn),
    .enablePin (enablePin),
    .opOn      (opOn),
    .evt       (evt)
  );

  alert_ctrl ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .evt          (evt),
    .rdStatusDone (rdStatusDone),
    .clrFaultsCmd (clrFaultsCmd),
    .alertLatched (alertLatched)
  );

  assign alertN = ~alertLatched;
endmodule

// File: tb/alert_latch_ctrl_tb_top.sv
`timescale 1ns/1ps
module alert_latch_ctrl_tb_top;
  localparam int NC = 12;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NC-1:0] condIn = '0;
  logic          rdStatusDone = 1'b0;
  logic          clrFaultsCmd = 1'b0;
  logic          enablePin = 1'b1;
  logic          opOn = 1'b1;
  logic          alertN;
  int            checks = 0;
  int            fails = 0;
  bit            done = 1'b0;

  always #2.5 clk = ~clk;

  alert_latch_ctrl #(.NUM_COND(NC)) dut_i (
    .clk(clk), .rstN(rstN), .condIn(condIn), .rdStatusDone(rdStatusDone),
    .clrFaultsCmd(clrFaultsCmd), .enablePin(enablePin), .opOn(opOn),
    .alertN(alertN)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input logic exp, input string req);
    checks++;
    if (alertN !== exp) begin
      fails++;
      $display("FAIL %s: alertN=%b expected=%b at %0t", req, alertN, exp, $time);
    end
  endtask

  // Bring the line low by toggling one flag on and back off.
  task automatic raise_alert(input int bitIdx);
    condIn[bitIdx] = 1'b1;
    step(1);
    condIn[bitIdx] = 1'b0;
    step(2);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(1'b1, "R1 during reset");
    step(2);
    rstN = 1'b1;
    step(4);
    chk(1'b1, "R1 after reset idle");
  endtask

  task automatic t_change_latch;
    condIn = 12'h008;
    step(1);
    chk(1'b1, "R2 one edge after change");
    step(1);
    chk(1'b0, "R2 two edges after change");
    step(5);
    chk(1'b0, "R3 held with no clear");
  endtask

  task automatic t_read_clear;
    rdStatusDone = 1'b1;
    step(1);
    rdStatusDone = 1'b0;
    chk(1'b1, "R4 status read releases");
    step(1);
    chk(1'b0, "R8 re-assert with flag set");
  endtask

  task automatic t_falling_change;
    condIn = '0;
    rdStatusDone = 1'b1;
    step(1);
    rdStatusDone = 1'b0;
    chk(1'b1, "R4 release before falling change");
    step(1);
    chk(1'b0, "R2 falling change latches");
  endtask

  task automatic t_clear_faults;
    clrFaultsCmd = 1'b1;
    step(1);
    clrFaultsCmd = 1'b0;
    chk(1'b1, "R5 clear-faults releases");
    step(3);
    chk(1'b1, "R8 stays high with no flag set");
  endtask

  task automatic t_pin_cycle;
    raise_alert(7);
    chk(1'b0, "R2 alert before pin cycle");
    enablePin = 1'b0;
    step(3);
    chk(1'b0, "R6 pin low alone keeps alert");
    enablePin = 1'b1;
    step(1);
    chk(1'b1, "R6 pin re-enable releases");
    step(2);
    chk(1'b1, "R8 no re-assert after pin cycle");
  endtask

  task automatic t_op_cycle;
    raise_alert(11);
    opOn = 1'b0;
    step(3);
    chk(1'b0, "R7 op off alone keeps alert");
    opOn = 1'b1;
    step(1);
    chk(1'b1, "R7 op re-on releases");
    step(2);
    chk(1'b1, "R8 no re-assert after op cycle");
  endtask

  task automatic t_simultaneous;
    condIn = 12'h002;
    step(1);
    rdStatusDone = 1'b1;
    step(1);
    rdStatusDone = 1'b0;
    chk(1'b0, "R9 change beats clear");
  endtask

  task automatic t_multi_reassert;
    condIn = 12'hFFF;
    step(2);
    chk(1'b0, "R2 many flags");
    clrFaultsCmd = 1'b1;
    step(1);
    clrFaultsCmd = 1'b0;
    chk(1'b1, "R5 release with all flags");
    step(1);
    chk(1'b0, "R8 re-assert all flags");
    step(4);
    chk(1'b0, "R3 re-latched holds");
    condIn = '0;
    step(2);
    clrFaultsCmd = 1'b1;
    step(1);
    clrFaultsCmd = 1'b0;
    step(3);
    chk(1'b1, "R8 quiet after final clear");
  endtask

  initial begin
    t_reset();
    t_change_latch();
    t_read_clear();
    t_falling_change();
    t_clear_faults();
    t_pin_cycle();
    t_op_cycle();
    t_simultaneous();
    t_multi_reassert();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule